// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block is the host-visible register window of a two-channel bus-master disk DMA engine. Each channel owns an 8-byte slot. The slot holds a command byte, a status byte and a 32-bit pointer to the descriptor table. The host reaches the window through a simple 32-bit port: a byte address, four byte enables, write data, and write and read strobes. Bytes, halfwords and words are all expressed through the byte enables. Read data comes back one cycle after the read strobe.

The status byte mixes three kinds of bit:
- Bits 5 and 6 are plain read/write storage.
- Bits 1 (error) and 2 (interrupt) are cleared by writing a one.
- Bit 0 (active) ignores host writes.

The DMA engine sits beside the window. It sees every register on dedicated outputs and sets status bits 0 to 2 through per-channel strobes. When the host flips command bit 0, the engine receives a one-cycle pulse.

Top module: `bmdma_regfile`

## Requirements
- R1: While reset is high, and in the cycle after it, the command, status and pointer registers of every channel are zero.
- R2: Address bit 3 selects the channel and address bit 2 selects the word in its slot. Address bits 1:0 are ignored. A read of word 0 returns {0xFF, status, 0xFF, command} from byte lane 3 down to lane 0. A read of word 1 returns the pointer. The data appears on the cycle after the read strobe.
- R3: A host write to status (word 0, lane 2 enabled) loads bits 5 and 6 from the written value.
- R4: Status bit 0 is unchanged by any host write. Once set, it stays set until reset.
- R5: For status bits 1 and 2, writing one clears the bit and writing zero leaves it unchanged.
- R6: Status bits 3, 4 and 7 always read zero.
- R7: Hardware strobes set status bits 0, 1 and 2 on the next edge. A strobe beats a same-cycle host write that tries to clear the same bit.
- R8: A host write with lane 0 enabled in word 0 loads the command byte. The channel's toggle output is high for exactly the cycle after a write that changes command bit 0, and is low otherwise.
- R9: A pointer write (word 1) updates only the enabled byte lanes.
- R10: Pointer bits 1:0 always read zero.
- R11: Writes to lanes 1 and 3 of word 0 have no effect. A write to one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Byte address in the window |
| host_be | input | 4 | Byte-lane enables |
| host_wdata | input | 32 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Registered read data |
| hw_set_active | input | 2 | Per-channel set of status bit 0 |
| hw_set_err | input | 2 | Per-channel set of status bit 1 |
| hw_set_irq | input | 2 | Per-channel set of status bit 2 |
| cmd_out | output | 16 | Command bytes, channel 0 in the low byte |
| status_out | output | 16 | Status bytes, channel 0 in the low byte |
| ptr_out | output | 64 | Descriptor pointers, channel 0 in the low word |
| start_toggle | output | 2 | One-cycle pulse per channel when command bit 0 changes |

## Verification
The assertions watch, on every cycle, the following properties:
- the reserved status bits stay zero;
- the pointer stays aligned;
- the active bit is sticky;
- a hardware set always lands, even against a clearing write;
- the toggle pulse appears only after a write that changes command bit 0;
- reset clears every register.

The exact effect of each status write value is shown only by the bench's sweeps, which cover every byte value with the active bit both clear and set. The same holds for the per-lane pointer merge under every byte-enable pattern, the read-data layout, and the isolation of one channel from the other.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BYTE_W    = 8;
  localparam int HOST_W    = 32;
  localparam int LANES     = HOST_W / BYTE_W;
  localparam int SLOT_BITS = 3;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] MASK_PLAIN = 8'h60;
  localparam logic [7:0] MASK_W1C   = 8'h06;
  localparam logic [7:0] MASK_HOLD  = 8'h01;
  localparam logic [7:0] PTR_LOW_KEEP = 8'hFC;

  // Host write rule for the status byte: plain bits copied, hold bit kept,
  // write-one-to-clear bits cleared where the written value has a one.
  function automatic logic [7:0] status_host_merge(input logic [7:0] cur,
                                                   input logic [7:0] wv);
    return (wv & MASK_PLAIN) | (cur & MASK_HOLD) | (cur & ~wv & MASK_W1C);
  endfunction
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_we,
  input  logic                      stat_we,
  input  logic [PTR_W/BYTE_W-1:0]   ptr_be,
  input  logic [HOST_W-1:0]         wdata,
  input  logic [2:0]                hw_set,
  output logic [BYTE_W-1:0]         cmd_q,
  output logic [BYTE_W-1:0]         stat_q,
  output logic [PTR_W-1:0]          ptr_q,
  output logic                      toggle_q
);
  localparam int PTR_LANES = PTR_W / BYTE_W;

  logic [BYTE_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (stat_we) stat_nxt = status_host_merge(stat_q, wdata[2*BYTE_W +: BYTE_W]);
    stat_nxt = stat_nxt | {5'b0, hw_set};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      toggle_q <= 1'b0;
      stat_q   <= '0;
    end else begin
      toggle_q <= cmd_we && (wdata[0] != cmd_q[0]);
      if (cmd_we) cmd_q <= wdata[BYTE_W-1:0];
      stat_q <= stat_nxt;
    end
  end

  for (genvar g = 0; g < PTR_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g*BYTE_W +: BYTE_W] <= '0;
      end else if (ptr_be[g]) begin
        if (g == 0) ptr_q[g*BYTE_W +: BYTE_W] <= wdata[g*BYTE_W +: BYTE_W] & PTR_LOW_KEEP;
        else        ptr_q[g*BYTE_W +: BYTE_W] <= wdata[g*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PTR_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd,
  input  logic [SEL_W-1:0]          sel,
  input  logic [NUM_CH*BYTE_W-1:0]  cmd_all,
  input  logic [NUM_CH*BYTE_W-1:0]  stat_all,
  input  logic [NUM_CH*PTR_W-1:0]   ptr_all,
  output logic [HOST_W-1:0]         rdata
);
  logic [HOST_W-1:0] mux_d;
  int                ch;

  always_comb begin
    ch    = int'(sel[SEL_W-1:1]);
    mux_d = '0;
    if (ch < NUM_CH) begin
      if (sel[0]) mux_d = ptr_all[ch*PTR_W +: PTR_W];
      else        mux_d = {FILL_BYTE, stat_all[ch*BYTE_W +: BYTE_W],
                           FILL_BYTE, cmd_all[ch*BYTE_W +: BYTE_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux_d;
  end
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PTR_W  = 32,
  parameter int ADDR_W = $clog2(NUM_CH) + SLOT_BITS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [LANES-1:0]          host_be,
  input  logic [HOST_W-1:0]         host_wdata,
  input  logic                      host_wr,
  input  logic                      host_rd,
  output logic [HOST_W-1:0]         host_rdata,
  input  logic [NUM_CH-1:0]         hw_set_active,
  input  logic [NUM_CH-1:0]         hw_set_err,
  input  logic [NUM_CH-1:0]         hw_set_irq,
  output logic [NUM_CH*BYTE_W-1:0]  cmd_out,
  output logic [NUM_CH*BYTE_W-1:0]  status_out,
  output logic [NUM_CH*PTR_W-1:0]   ptr_out,
  output logic [NUM_CH-1:0]         start_toggle
);
  localparam int SEL_W = ADDR_W - 2;
  localparam int CH_W  = ADDR_W - SLOT_BITS;

  logic [SEL_W-1:0] sel;
  logic             unused_lowaddr;

  assign sel            = host_addr[ADDR_W-1:2];
  assign unused_lowaddr = ^host_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_ctl, hit_ptr;
    assign hit_ctl = host_wr && (sel[SEL_W-1:1] == CH_W'(c)) && !sel[0];
    assign hit_ptr = host_wr && (sel[SEL_W-1:1] == CH_W'(c)) &&  sel[0];

    bmdma_chan #(.PTR_W(PTR_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cmd_we   (hit_ctl && host_be[0]),
      .stat_we  (hit_ctl && host_be[2]),
      .ptr_be   (host_be & {LANES{hit_ptr}}),
      .wdata    (host_wdata),
      .hw_set   ({hw_set_irq[c], hw_set_err[c], hw_set_active[c]}),
      .cmd_q    (cmd_out[c*BYTE_W +: BYTE_W]),
      .stat_q   (status_out[c*BYTE_W +: BYTE_W]),
      .ptr_q    (ptr_out[c*PTR_W +: PTR_W]),
      .toggle_q (start_toggle[c])
    );
  end

  bmdma_rdmux #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .SEL_W(SEL_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (host_rd),
    .sel      (sel),
    .cmd_all  (cmd_out),
    .stat_all (status_out),
    .ptr_all  (ptr_out),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
  parameter int NUM_CH = 2,
  parameter int PTR_W  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  host_wr,
  input logic [NUM_CH-1:0]     hw_set_active,
  input logic [NUM_CH-1:0]     hw_set_err,
  input logic [NUM_CH-1:0]     hw_set_irq,
  input logic [NUM_CH*8-1:0]   cmd_out,
  input logic [NUM_CH*8-1:0]   status_out,
  input logic [NUM_CH*PTR_W-1:0] ptr_out,
  input logic [NUM_CH-1:0]     start_toggle
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (cmd_out[c*8 +: 8] == 8'h00 && status_out[c*8 +: 8] == 8'h00 &&
               ptr_out[c*PTR_W +: PTR_W] == '0)); // R1
    AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (rst)
      status_out[c*8] |=> status_out[c*8]); // R4
    AST_HW_ACTIVE_SETS: assert property (@(posedge clk) disable iff (rst)
      hw_set_active[c] |=> status_out[c*8]); // R7
    AST_HW_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
      hw_set_err[c] |=> status_out[c*8+1]); // R7
    AST_HW_IRQ_WINS: assert property (@(posedge clk) disable iff (rst)
      hw_set_irq[c] |=> status_out[c*8+2]); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (status_out[c*8+3] == 1'b0 && status_out[c*8+4] == 1'b0 &&
       status_out[c*8+7] == 1'b0)); // R6
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      ptr_out[c*PTR_W +: 2] == 2'b00); // R10
    AST_TOGGLE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
      start_toggle[c] |-> (cmd_out[c*8] != $past(cmd_out[c*8]))); // R8
    AST_TOGGLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
      start_toggle[c] |-> $past(host_wr)); // R8
  end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_wr       (host_wr),
  .hw_set_active (hw_set_active),
  .hw_set_err    (hw_set_err),
  .hw_set_irq    (hw_set_irq),
  .cmd_out       (cmd_out),
  .status_out    (status_out),
  .ptr_out       (ptr_out),
  .start_toggle  (start_toggle)
);

// File: tb/bmdma_regfile_bench.sv
module bmdma_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_addr = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic [1:0]  hw_set_active = '0, hw_set_err = '0, hw_set_irq = '0;
  logic [15:0] cmd_out, status_out;
  logic [63:0] ptr_out;
  logic [1:0]  start_toggle;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_stat[2];
  logic [31:0] m_ptr [2];
  logic [1:0]  m_tog;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regfile u_bmdma_regfile (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_be(host_be),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .hw_set_active(hw_set_active),
    .hw_set_err(hw_set_err), .hw_set_irq(hw_set_irq), .cmd_out(cmd_out),
    .status_out(status_out), .ptr_out(ptr_out), .start_toggle(start_toggle)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge; one host cycle plus hardware strobes.
  task automatic cycle(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [3:0] be, input logic [31:0] wd,
                       input logic [2:0] hw0, input logic [2:0] hw1);
    host_wr = wr; host_rd = rd; host_addr = a; host_be = be; host_wdata = wd;
    hw_set_active = {hw1[0], hw0[0]};
    hw_set_err    = {hw1[1], hw0[1]};
    hw_set_irq    = {hw1[2], hw0[2]};
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; hw_set_active = '0; hw_set_err = '0; hw_set_irq = '0;
    for (int c = 0; c < 2; c++) begin
      logic [7:0] s;
      logic [2:0] hw;
      bit hit;
      hw  = (c == 0) ? hw0 : hw1;
      hit = wr && (a[3] == c[0]);
      s   = m_stat[c];
      m_tog[c] = 1'b0;
      if (hit && !a[2] && be[2])
        s = (wd[23:16] & 8'h60) | (s & 8'h01) | (s & ~wd[23:16] & 8'h06);
      m_stat[c] = s | {5'b0, hw};
      if (hit && !a[2] && be[0]) begin
        m_tog[c] = (wd[0] != m_cmd[c][0]);
        m_cmd[c] = wd[7:0];
      end
      if (hit && a[2]) begin
        for (int k = 0; k < 4; k++) if (be[k]) m_ptr[c][8*k +: 8] = wd[8*k +: 8];
        m_ptr[c][1:0] = 2'b00;
      end
    end
  endtask

  task automatic read_check(input int c, input bit word, input string req);
    cycle(1'b0, 1'b1, {c[0], word, 2'b00}, 4'h0, 32'h0, 3'b0, 3'b0);
    check(req, host_rdata, word ? m_ptr[c] : {8'hFF, m_stat[c], 8'hFF, m_cmd[c]});
  endtask

  task automatic outputs_check(input string req);
    for (int c = 0; c < 2; c++) begin
      check(req, {24'h0, cmd_out[c*8 +: 8]}, {24'h0, m_cmd[c]});
      check(req, {24'h0, status_out[c*8 +: 8]}, {24'h0, m_stat[c]});
      check(req, ptr_out[c*32 +: 32], m_ptr[c]);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin m_cmd[c] = '0; m_stat[c] = '0; m_ptr[c] = '0; end
    m_tog = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    outputs_check("R1 reset state");
    rst = 1'b0;
    for (int c = 0; c < 2; c++) begin
      read_check(c, 1'b0, "R1/R2 reset word0 layout");
      read_check(c, 1'b1, "R1/R2 reset pointer");
    end

    // R8: command sweep with toggle pulse
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        cycle(1'b1, 1'b0, {c[0], 3'b000}, 4'b0001, {24'h0, v[7:0]}, 3'b0, 3'b0);
        check("R8 toggle pulse", {30'h0, start_toggle}, {30'h0, m_tog});
        check("R8 command load", {24'h0, cmd_out[c*8 +: 8]}, {24'h0, m_cmd[c]});
      end
      read_check(c, 1'b0, "R2 command readback");
    end
    // R8: pulse is one cycle wide
    cycle(1'b1, 1'b0, 4'h0, 4'b0001, 32'h1 ^ {31'h0, m_cmd[0][0]}, 3'b0, 3'b0);
    check("R8 pulse present", {30'h0, start_toggle}, 32'h1);
    cycle(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, 3'b0, 3'b0);
    check("R8 pulse one cycle", {30'h0, start_toggle}, 32'h0);

    // R11: lanes 1 and 3 of word 0 ignored
    for (int c = 0; c < 2; c++) begin
      cycle(1'b1, 1'b0, {c[0], 3'b001}, 4'b1010, 32'hFFFF_FFFF, 3'b0, 3'b0);
      read_check(c, 1'b0, "R11 lanes 1/3 ignored");
    end

    // R3/R4/R5/R6: status sweep, active clear then active set
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 2; c++) begin
        if (pass == 1)
          cycle(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, (c == 0) ? 3'b001 : 3'b000,
                (c == 1) ? 3'b001 : 3'b000);
        for (int v = 0; v < 256; v++) begin
          if (v % 4 == 0)
            cycle(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, (c == 0) ? 3'b110 : 3'b000,
                  (c == 1) ? 3'b110 : 3'b000);
          cycle(1'b1, 1'b0, {c[0], 3'b010}, 4'b0100, {8'h0, v[7:0], 16'h0}, 3'b0, 3'b0);
          read_check(c, 1'b0, "R3/R4/R5/R6 status write rule");
          check("R11 other channel status", {24'h0, status_out[(1-c)*8 +: 8]},
                {24'h0, m_stat[1-c]});
        end
      end
    end

    // R7: hardware set wins against same-cycle clear
    cycle(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, 3'b110, 3'b000);
    cycle(1'b1, 1'b0, 4'h0, 4'b0100, 32'h0006_0000, 3'b010, 3'b000);
    check("R7 err set beats clear", {24'h0, status_out[7:0] & 8'h06}, 32'h02);
    cycle(1'b1, 1'b0, 4'h8, 4'b0100, 32'h0006_0000, 3'b000, 3'b100);
    check("R7 irq set beats clear", {24'h0, status_out[15:8] & 8'h06}, 32'h04);
    outputs_check("R7 model match");

    // R9/R10: pointer byte-enable sweep
    for (int c = 0; c < 2; c++) begin
      for (int be = 0; be < 16; be++) begin
        logic [31:0] wd;
        wd = 32'hA55A_3CC3 ^ (be * 32'h0103_0507) ^ c;
        cycle(1'b1, 1'b0, {c[0], 3'b100}, be[3:0], wd, 3'b0, 3'b0);
        read_check(c, 1'b1, "R9/R10 pointer lane merge");
        check("R11 other channel pointer", ptr_out[(1-c)*32 +: 32], m_ptr[1-c]);
      end
    end
    cycle(1'b1, 1'b0, 4'hC, 4'hF, 32'hFFFF_FFFF, 3'b0, 3'b0);
    check("R10 pointer aligned", ptr_out[63:32], 32'hFFFF_FFFC);

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    outputs_check("R1 mid-run reset");
    check("R1 toggle cleared", {30'h0, start_toggle}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule